// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers 26 interrupt sources for a small embedded microcontroller. Each source raises a one-cycle pulse that is latched into a request bit. A per-source enable bit masks the request. A per-source priority bit places the source in the high or the low level. The controller presents one interrupt request line and a five-bit source index to the CPU. It picks the winner first by level and then by a fixed ascending index.

Software reaches the three bit sets through an 8-bit special-function-register bus. Writes are strobed and reads are combinational. Each set occupies four consecutive byte addresses. When the CPU acknowledges the presented source, its request bit is cleared and its level is recorded as in service. This allows a high-level source to preempt a low-level handler, while nothing preempts a high-level handler. A return strobe undoes the most recent level.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every enable, request and priority register reads 0x00, `irq` is low and no level is in service.
- R2: Source i is held in bit i%8 of the byte at base+i/8. The enable base is 0xE1, the request base is 0xE9 and the priority base is 0xF1. Bits 7..2 of the fourth byte of each set read 0 and ignore writes. Any other address reads 0x00 and changes no register.
- R3: A one-cycle pulse on `src_pulse[i]` sets request bit i, and the bit reads back as 1 from the next cycle on. A software write loads the request byte, so writing 0 clears a bit and writing 1 sets it.
- R4: When a pulse and a software write of 0 reach the same request bit in the same cycle, the bit ends at 1.
- R5: `irq` is high only when some source has both its request and enable bits set and its level is currently allowed. `irq_vec` then names such a source.
- R6: If any allowed high-level source (priority bit 1) is pending, the winner is high-level, whatever the indices.
- R7: Among pending sources of the same level, the lowest index wins.
- R8: `irq_ack` while `irq` is high and `irq_ret` is low clears request bit `irq_vec` and marks that source's level as in service. Otherwise `irq_ack` is ignored. A pulse of the same source in the acknowledge cycle leaves the request bit set.
- R9: While a high level is in service, `irq` stays low. While only a low level is in service, only high-level sources raise `irq`.
- R10: `irq_ret` removes the high level from service if it is present, otherwise the low level. With nothing in service it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sfr_addr | input | 8 | Register address for reads and writes |
| sfr_wr | input | 1 | Write strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data for `sfr_addr` (combinational) |
| src_pulse | input | 26 | One-cycle request pulses, bit i for source i |
| irq | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 5 | Index of the presented source |
| irq_ack | input | 1 | CPU acknowledge of the presented source |
| irq_ret | input | 1 | Return-from-interrupt strobe |

## Verification
A request bit can be set by its source pulse in the same cycle that it is cleared, either by a software write of 0 or by the CPU acknowledging that source. The bench drives both collisions in one clock. It then reads the request byte back over the register bus and expects the bit to stay set. For the acknowledge case, it also expects `irq` to drop, because the low level went into service. The acknowledge and return strobes are also driven together, and the bench expects the pending source to remain presented with its request bit intact.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int unsigned NSRC_DEF = 26;
  localparam int unsigned REG_W    = 8;
  localparam logic [7:0]  EN_BASE  = 8'hE1;
  localparam logic [7:0]  REQ_BASE = 8'hE9;
  localparam logic [7:0]  PRI_BASE = 8'hF1;

  typedef enum logic [1:0] {
    SVC_NONE  = 2'd0,
    SVC_LO    = 2'd1,
    SVC_HI    = 2'd2,
    SVC_LO_HI = 2'd3
  } svc_t;
endpackage

// File: rtl/icu_sfr_bank.sv
module icu_sfr_bank
  import icu_pkg::*;
#(
  parameter int unsigned NBITS = NSRC_DEF,
  parameter logic [7:0]  BASE  = EN_BASE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [NBITS-1:0]  set_bits,
  input  logic [NBITS-1:0]  clr_bits,
  output logic [NBITS-1:0]  bits_q,
  output logic [REG_W-1:0]  rd_data
);
  localparam int unsigned NREG = (NBITS + REG_W - 1) / REG_W;
  localparam int unsigned PADW = NREG * REG_W;

  logic [NREG-1:0]  hit;
  logic [NBITS-1:0] bits_d;
  logic [PADW-1:0]  padded;
  logic             upd;

  always_comb begin
    for (int r = 0; r < int'(NREG); r++) begin
      hit[r] = (addr == BASE + 8'(r));
    end
  end

  for (genvar i = 0; i < int'(NBITS); i++) begin : g_bit
    localparam int unsigned RI = i / REG_W;
    localparam int unsigned KI = i % REG_W;
    always_comb begin
      bits_d[i] = (wr_en && hit[RI]) ? wdata[KI] : bits_q[i];
      if (clr_bits[i]) bits_d[i] = 1'b0;
      if (set_bits[i]) bits_d[i] = 1'b1;
    end
  end

  assign upd = (wr_en && (|hit)) || (|set_bits) || (|clr_bits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else if (upd) begin
      bits_q <= bits_d;
    end
  end

  assign padded = PADW'(bits_q);

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < int'(NREG); r++) begin
      if (hit[r]) rd_data = padded[r*REG_W +: REG_W];
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_bits != '0) |=> ((bits_q & $past(set_bits)) == $past(set_bits))); // R4
endmodule

// File: rtl/icu_arbiter.sv
module icu_arbiter #(
  parameter int unsigned NSRC = 26,
  parameter int unsigned VW   = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] pend_hi,
  input  logic [NSRC-1:0] pend_lo,
  input  logic            allow_hi,
  input  logic            allow_lo,
  output logic            grant,
  output logic            grant_hi,
  output logic [VW-1:0]   grant_vec
);
  logic [NSRC-1:0] cand_hi;
  logic [NSRC-1:0] cand_lo;
  logic [VW-1:0]   idx_hi;
  logic [VW-1:0]   idx_lo;

  assign cand_hi = allow_hi ? pend_hi : '0;
  assign cand_lo = allow_lo ? pend_lo : '0;

  always_comb begin
    idx_hi = '0;
    idx_lo = '0;
    for (int i = int'(NSRC) - 1; i >= 0; i--) begin
      if (cand_hi[i]) idx_hi = VW'(i);
      if (cand_lo[i]) idx_lo = VW'(i);
    end
  end

  always_comb begin
    grant_hi  = |cand_hi;
    grant     = grant_hi || (|cand_lo);
    grant_vec = grant_hi ? idx_hi : idx_lo;
  end
endmodule

// File: rtl/icu_nest.sv
module icu_nest
  import icu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic push_hi,
  input  logic pop,
  output logic allow_hi,
  output logic allow_lo,
  output logic busy_hi,
  output logic busy_lo
);
  svc_t state_q;
  svc_t state_d;

  always_comb begin
    state_d = state_q;
    if (pop) begin
      case (state_q)
        SVC_LO_HI: state_d = SVC_LO;
        default:   state_d = SVC_NONE;
      endcase
    end else if (push) begin
      case (state_q)
        SVC_NONE: state_d = push_hi ? SVC_HI : SVC_LO;
        SVC_LO:   state_d = push_hi ? SVC_LO_HI : SVC_LO;
        default:  state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SVC_NONE;
    end else if (push || pop) begin
      state_q <= state_d;
    end
  end

  assign busy_hi  = (state_q == SVC_HI) || (state_q == SVC_LO_HI);
  assign busy_lo  = (state_q == SVC_LO) || (state_q == SVC_LO_HI);
  assign allow_hi = !busy_hi;
  assign allow_lo = (state_q == SVC_NONE);

  AST_POP_HI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && state_q == SVC_LO_HI) |=> (state_q == SVC_LO)); // R10
  AST_PUSH_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (push && push_hi && !pop) |=> busy_hi); // R8
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import icu_pkg::*;
#(
  parameter int unsigned NSRC = NSRC_DEF,
  localparam int unsigned VW  = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      sfr_addr,
  input  logic            sfr_wr,
  input  logic [7:0]      sfr_wdata,
  output logic [7:0]      sfr_rdata,
  input  logic [NSRC-1:0] src_pulse,
  output logic            irq,
  output logic [VW-1:0]   irq_vec,
  input  logic            irq_ack,
  input  logic            irq_ret
);
  logic [1:0]      rst_sync;
  logic            rst_core_n;
  logic [NSRC-1:0] en_q, req_q, pri_q;
  logic [NSRC-1:0] ack_clr;
  logic [7:0]      rd_en, rd_req, rd_pri;
  logic            take, grant_hi;
  logic            allow_hi, allow_lo, busy_hi, busy_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  assign take = irq && irq_ack && !irq_ret;

  always_comb begin
    ack_clr = '0;
    if (take) ack_clr[irq_vec] = 1'b1;
  end

  icu_sfr_bank #(.NBITS(NSRC), .BASE(EN_BASE)) u_en (
    .clk(clk), .rst_n(rst_core_n), .wr_en(sfr_wr), .addr(sfr_addr),
    .wdata(sfr_wdata), .set_bits('0), .clr_bits('0),
    .bits_q(en_q), .rd_data(rd_en));

  icu_sfr_bank #(.NBITS(NSRC), .BASE(REQ_BASE)) u_req (
    .clk(clk), .rst_n(rst_core_n), .wr_en(sfr_wr), .addr(sfr_addr),
    .wdata(sfr_wdata), .set_bits(src_pulse), .clr_bits(ack_clr),
    .bits_q(req_q), .rd_data(rd_req));

  icu_sfr_bank #(.NBITS(NSRC), .BASE(PRI_BASE)) u_pri (
    .clk(clk), .rst_n(rst_core_n), .wr_en(sfr_wr), .addr(sfr_addr),
    .wdata(sfr_wdata), .set_bits('0), .clr_bits('0),
    .bits_q(pri_q), .rd_data(rd_pri));

  assign sfr_rdata = rd_en | rd_req | rd_pri;

  icu_arbiter #(.NSRC(NSRC), .VW(VW)) u_arb (
    .pend_hi(req_q & en_q & pri_q),
    .pend_lo(req_q & en_q & ~pri_q),
    .allow_hi(allow_hi), .allow_lo(allow_lo),
    .grant(irq), .grant_hi(grant_hi), .grant_vec(irq_vec));

  icu_nest u_nest (
    .clk(clk), .rst_n(rst_core_n),
    .push(take), .push_hi(grant_hi), .pop(irq_ret),
    .allow_hi(allow_hi), .allow_lo(allow_lo),
    .busy_hi(busy_hi), .busy_lo(busy_lo));

  AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (!rst_core_n)
    irq |-> (req_q[irq_vec] && en_q[irq_vec])); // R5
  AST_HI_WINS: assert property (@(posedge clk) disable iff (!rst_core_n)
    (irq && !pri_q[irq_vec]) |-> ((req_q & en_q & pri_q) == '0)); // R6
  AST_HI_SILENT: assert property (@(posedge clk) disable iff (!rst_core_n)
    busy_hi |-> !irq); // R9
  AST_LO_ONLY_HI: assert property (@(posedge clk) disable iff (!rst_core_n)
    (busy_lo && irq) |-> pri_q[irq_vec]); // R9
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_core_n)
    (take && !src_pulse[irq_vec]) |=> !req_q[$past(irq_vec)]); // R8
endmodule

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sfr_addr = '0;
  logic        sfr_wr = 1'b0;
  logic [7:0]  sfr_wdata = '0;
  logic [7:0]  sfr_rdata;
  logic [25:0] src_pulse = '0;
  logic        irq;
  logic [4:0]  irq_vec;
  logic        irq_ack = 1'b0;
  logic        irq_ret = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .src_pulse(src_pulse),
    .irq(irq), .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_ret(irq_ret));

  localparam int NT = 8;
  localparam logic [25:0] ALL = 26'h3FFFFFF;
  localparam logic [25:0] T_EN  [NT] = '{ALL, ALL, ALL, ALL & ~26'(1 << 5), ALL, ALL, 26'h0, ALL};
  localparam logic [25:0] T_PRI [NT] = '{26'h0, 26'h0, 26'(1 << 20), 26'h0,
                                         26'h3000000, ALL, 26'h0, 26'h0};
  localparam logic [25:0] T_REQ [NT] = '{26'(1 << 3), 26'h100020, 26'h100020, 26'h20,
                                         26'h3000001, 26'h2000080, ALL, 26'h2000000};
  localparam logic        T_IRQ [NT] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic [4:0]  T_VEC [NT] = '{5'd3, 5'd5, 5'd20, 5'd0, 5'd24, 5'd7, 5'd0, 5'd25};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    @(negedge clk);
    sfr_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    sfr_addr = a;
    #1;
    chk(sfr_rdata == exp, tag, sfr_rdata, exp);
  endtask

  task automatic pulse(input logic [25:0] m);
    @(negedge clk); src_pulse = m;
    @(negedge clk); src_pulse = '0;
  endtask

  task automatic strobe(input bit ack, input bit ret);
    @(negedge clk); irq_ack = ack; irq_ret = ret;
    @(negedge clk); irq_ack = 1'b0; irq_ret = 1'b0;
  endtask

  task automatic load(input logic [7:0] base, input logic [25:0] m);
    logic [31:0] p;
    p = {6'b0, m};
    for (int b = 0; b < 4; b++) wr(base + 8'(b), p[b*8 +: 8]);
  endtask

  task automatic irq_chk(input logic exp_irq, input logic [4:0] exp_vec, input string tag);
    #1;
    chk(irq == exp_irq, tag, irq, exp_irq);
    if (exp_irq) chk(irq_vec == exp_vec, tag, irq_vec, exp_vec);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state of every register and the request line
    for (int b = 0; b < 4; b++) begin
      rd_chk(8'hE1 + 8'(b), 8'h00, "R1 enable reset");
      rd_chk(8'hE9 + 8'(b), 8'h00, "R1 request reset");
      rd_chk(8'hF1 + 8'(b), 8'h00, "R1 priority reset");
    end
    irq_chk(1'b0, 5'd0, "R1 irq reset");

    // R2: reserved bits and unmapped address
    wr(8'hE4, 8'hFF);
    rd_chk(8'hE4, 8'h03, "R2 reserved bits");
    wr(8'hE5, 8'hFF);
    rd_chk(8'hE5, 8'h00, "R2 unmapped read");
    rd_chk(8'hE4, 8'h03, "R2 unmapped write no effect");
    wr(8'hE4, 8'h00);

    // R3: software load of request bits and pulse latching
    wr(8'hE9, 8'h10);
    rd_chk(8'hE9, 8'h10, "R3 software set");
    wr(8'hE9, 8'h00);
    rd_chk(8'hE9, 8'h00, "R3 software clear");
    pulse(26'(1 << 17));
    rd_chk(8'hEB, 8'h02, "R3 pulse latch");
    wr(8'hEB, 8'h00);

    // R4: pulse and write-0 in the same cycle
    @(negedge clk);
    sfr_addr = 8'hE9; sfr_wdata = 8'h00; sfr_wr = 1'b1; src_pulse = 26'h2;
    @(negedge clk);
    sfr_wr = 1'b0; src_pulse = '0;
    rd_chk(8'hE9, 8'h02, "R4 set beats clear");
    wr(8'hE9, 8'h00);

    // R5 R6 R7: table of masks, levels and requests
    for (int t = 0; t < NT; t++) begin
      load(8'hE9, 26'h0);
      load(8'hE1, T_EN[t]);
      load(8'hF1, T_PRI[t]);
      pulse(T_REQ[t]);
      irq_chk(T_IRQ[t], T_VEC[t], $sformatf("R5 R6 R7 table %0d", t));
    end
    load(8'hE9, 26'h0);

    // R8 R9 R10: nesting
    load(8'hE1, ALL);
    load(8'hF1, 26'(1 << 10));
    pulse(26'(1 << 2));
    irq_chk(1'b1, 5'd2, "R7 low source presented");
    strobe(1'b1, 1'b0);
    irq_chk(1'b0, 5'd0, "R8 irq drops after ack");
    rd_chk(8'hE9, 8'h00, "R8 ack clears request");
    pulse(26'(1 << 3));
    irq_chk(1'b0, 5'd0, "R9 low blocked under low");
    pulse(26'(1 << 10));
    irq_chk(1'b1, 5'd10, "R9 high preempts low");
    strobe(1'b1, 1'b0);
    irq_chk(1'b0, 5'd0, "R9 nothing under high");
    strobe(1'b0, 1'b1);
    irq_chk(1'b0, 5'd0, "R10 pop high keeps low");
    strobe(1'b0, 1'b1);
    irq_chk(1'b1, 5'd3, "R10 pop low releases");
    strobe(1'b1, 1'b0);
    strobe(1'b0, 1'b1);
    irq_chk(1'b0, 5'd0, "R10 back to idle");

    // R8: ack without irq is ignored
    strobe(1'b1, 1'b0);
    pulse(26'(1 << 4));
    irq_chk(1'b1, 5'd4, "R8 idle ack ignored");

    // R8: ack together with return is ignored
    strobe(1'b1, 1'b1);
    irq_chk(1'b1, 5'd4, "R8 ack with ret ignored");
    rd_chk(8'hE9, 8'h10, "R8 request kept with ret");

    // R8: ack and same-source pulse in one cycle
    @(negedge clk);
    irq_ack = 1'b1; src_pulse = 26'(1 << 4);
    @(negedge clk);
    irq_ack = 1'b0; src_pulse = '0;
    rd_chk(8'hE9, 8'h10, "R8 pulse beats ack clear");
    irq_chk(1'b0, 5'd0, "R9 low in service after ack");
    strobe(1'b0, 1'b1);
    irq_chk(1'b1, 5'd4, "R10 re-presented after return");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule